// File: doc/BRIEF.md
# SMBus Host Block Data Buffer

This block is the block-transfer store of an SMBus host controller. It keeps up to 32 data bytes, the SMBus block maximum, for block writes and block reads. Software reaches the store through one data register whose address never changes. A hidden index, which software cannot read, picks the byte. Every access to the data register moves the index forward by one. A read of the host control register rewinds the index to zero.

Before a block write, software puts the byte count in the count register and then writes the bytes to the data register in order. The transaction engine starts its transfer, which rewinds its own pointer, and pops the bytes in index order. During a block read the engine pushes the received bytes in index order and loads the count returned by the slave. Software then rewinds its index and drains the bytes. The block flags a count of zero, or a count above the depth, as a protocol error. Buffer mode works only while the buffer-enable bit of the auxiliary register is set.

Top module: `smb_blkbuf`

## Requirements
- R1: A synchronous reset clears the count register, the buffer-enable bit and both indices. After reset the count reads 0x00, the auxiliary register reads 0x00, `cnt_bad` is 1 and `buf_mode` is 0.
- R2: With buffer mode on, a write to the data register (`reg_sel`=2) stores the byte at the software index and advances the index. A read of the data register returns the byte at the index in the same cycle and advances the index.
- R3: A read of the host control register (`reg_sel`=0) returns 0x00 and rewinds the software index to zero, so the next data read returns entry 0.
- R4: The software index stops at DEPTH (32). A data write there changes no entry, and a data read there returns 0x00.
- R5: The count register (`reg_sel`=1) reads back the last value written. A count load from the engine takes the engine's value, even when software writes the count in the same cycle.
- R6: `cnt_bad` is 1 exactly when the count register holds 0 or a value above DEPTH. It follows a count change one cycle after the write.
- R7: In the auxiliary register (`reg_sel`=3) only bit 1, buffer enable, can be written. It reads back in bit 1, all other bits read 0, and `buf_mode` shows it one cycle after the write.
- R8: While buffer enable is 0, data-register writes, engine pushes and engine pops store nothing and move no index. Data reads and pops return 0x00.
- R9: `eng_start` rewinds the engine pointer to zero. Each pop then returns the next entry in index order on `eng_pop_data` in the same cycle.
- R10: Each engine push stores `eng_push_data` at the engine pointer and advances the pointer. Software can read the bytes back in the same order.
- R11: The engine pointer stops at DEPTH. A pop there returns 0x00 and a push there changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 0 host control, 1 count, 2 block data, 3 auxiliary |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register, valid in the strobe cycle |
| buf_mode | output | 1 | Buffer-enable bit |
| cnt_bad | output | 1 | Count outside 1..DEPTH |
| eng_start | input | 1 | Transaction start, rewinds the engine pointer |
| eng_pop | input | 1 | Engine takes the next byte to send |
| eng_pop_data | output | DW | Byte at the engine pointer |
| eng_push | input | 1 | Engine stores a received byte |
| eng_push_data | input | DW | Received byte |
| eng_cnt_ld | input | 1 | Engine loads the received count |
| eng_cnt_data | input | DW | Received count |

## Verification
Neither index can be seen at the ports, so a wrong index shows up only in the data. If the index is slipped, stuck or rewound at the wrong time, the very next data read or pop returns the neighbouring entry, a stale entry or 0x00. If the index saturates at the wrong place, an access at the edge of the store either overwrites entry 31 or returns a real byte where 0x00 is expected. This is seen only when the store is drained in full after a rewind. A wrong count or enable state is seen one cycle after the write, on `cnt_bad`, `buf_mode` or a read-back of the register.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
   typedef enum logic [1:0] {
      SEL_CTL = 2'd0,
      SEL_CNT = 2'd1,
      SEL_DAT = 2'd2,
      SEL_AUX = 2'd3
   } blk_sel_e;

   localparam int AUX_BUF_BIT = 1;
endpackage

// File: rtl/smb_blk_idx.sv
module smb_blk_idx #(
   parameter int DEPTH = 32,
   parameter int IW    = 6
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          clr,
   input  logic          adv,
   output logic [IW-1:0] idx
);
   localparam logic [IW-1:0] LAST = IW'(DEPTH);

   if (IW != $clog2(DEPTH + 1)) begin : g_bad_iw
      $error("smb_blk_idx: IW must hold 0..DEPTH");
   end

   always_ff @(posedge clk) begin
      if (srst || clr)
         idx <= '0;
      else if (adv && (idx < LAST))
         idx <= idx + 1'b1;
   end

   // R4: index never passes the end of the store
   a_r4_idx_bound: assert property (@(posedge clk) disable iff (srst)
      idx <= LAST);
   // R3 / R9: a rewind lands on entry zero
   a_r3_idx_rewind: assert property (@(posedge clk) disable iff (srst)
      clr |=> (idx == '0));
   // R2 / R10: one step per access below the end
   a_r2_idx_step: assert property (@(posedge clk) disable iff (srst)
      (adv && !clr && (idx < LAST)) |=> (idx == $past(idx) + 1'b1));
   // R4 / R11: saturation holds
   a_r4_idx_hold: assert property (@(posedge clk) disable iff (srst)
      (adv && !clr && (idx == LAST)) |=> (idx == LAST));
endmodule

// File: rtl/smb_blk_mem.sv
module smb_blk_mem #(
   parameter int DEPTH      = 32,
   parameter int DW         = 8,
   parameter int IW         = 6,
   parameter bit CLR_ON_RST = 1'b1
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          a_we,
   input  logic [IW-1:0] a_idx,
   input  logic [DW-1:0] a_d,
   output logic [DW-1:0] a_q,
   input  logic          b_we,
   input  logic [IW-1:0] b_idx,
   input  logic [DW-1:0] b_d,
   output logic [DW-1:0] b_q
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [IW-1:0] LAST = IW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("smb_blk_mem: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0][DW-1:0] ent;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DW-1:0] q;
      logic hit_a, hit_b;
      assign hit_a = a_we && (a_idx == IW'(e));
      assign hit_b = b_we && (b_idx == IW'(e));
      if (CLR_ON_RST) begin : g_rst
         always_ff @(posedge clk) begin
            if (srst)       q <= '0;
            else if (hit_b) q <= b_d;
            else if (hit_a) q <= a_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit_b)      q <= b_d;
            else if (hit_a) q <= a_d;
         end
      end
      assign ent[e] = q;
   end

   assign a_q = (a_idx < LAST) ? ent[a_idx[AW-1:0]] : '0;
   assign b_q = (b_idx < LAST) ? ent[b_idx[AW-1:0]] : '0;

   // R4 / R11: no write strobe reaches the store past its end
   a_r11_no_write_past_end: assert property (@(posedge clk) disable iff (srst)
      (a_we || b_we) |-> ((!a_we || (a_idx < LAST)) && (!b_we || (b_idx < LAST))));
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
   import smb_blk_pkg::*;
#(
   parameter int DEPTH      = 32,
   parameter int DW         = 8,
   parameter bit CLR_ON_RST = 1'b1
) (
   input  logic          clk,
   input  logic          srst,
   input  logic [1:0]    reg_sel,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          buf_mode,
   output logic          cnt_bad,
   input  logic          eng_start,
   input  logic          eng_pop,
   output logic [DW-1:0] eng_pop_data,
   input  logic          eng_push,
   input  logic [DW-1:0] eng_push_data,
   input  logic          eng_cnt_ld,
   input  logic [DW-1:0] eng_cnt_data
);
   localparam int IW = $clog2(DEPTH + 1);
   localparam logic [IW-1:0] LAST = IW'(DEPTH);
   localparam logic [DW-1:0] CNT_MAX = DW'(DEPTH);

   if (DW < 2 || (DEPTH + 1) > (1 << DW)) begin : g_bad_dw
      $error("smb_blkbuf: DW must hold a count of DEPTH");
   end

   blk_sel_e sel;
   assign sel = blk_sel_e'(reg_sel);

   logic          e32b;
   logic [DW-1:0] cnt;
   logic [IW-1:0] sw_idx, eng_idx;
   logic [DW-1:0] sw_q, eng_q;
   logic          sw_clr, sw_adv, sw_we;
   logic          eng_adv, eng_we;

   // software side index control
   assign sw_clr = reg_rd && (sel == SEL_CTL);
   assign sw_adv = e32b && (sel == SEL_DAT) && (reg_wr || reg_rd);
   assign sw_we  = e32b && (sel == SEL_DAT) && reg_wr && (sw_idx < LAST);

   // engine side index control
   assign eng_adv = e32b && (eng_pop || eng_push);
   assign eng_we  = e32b && eng_push && (eng_idx < LAST);

   smb_blk_idx #(.DEPTH(DEPTH), .IW(IW)) u_sw_idx (
      .clk(clk), .srst(srst), .clr(sw_clr), .adv(sw_adv), .idx(sw_idx));

   smb_blk_idx #(.DEPTH(DEPTH), .IW(IW)) u_eng_idx (
      .clk(clk), .srst(srst), .clr(eng_start), .adv(eng_adv), .idx(eng_idx));

   smb_blk_mem #(.DEPTH(DEPTH), .DW(DW), .IW(IW), .CLR_ON_RST(CLR_ON_RST)) u_mem (
      .clk(clk), .srst(srst),
      .a_we(sw_we), .a_idx(sw_idx), .a_d(reg_wdata), .a_q(sw_q),
      .b_we(eng_we), .b_idx(eng_idx), .b_d(eng_push_data), .b_q(eng_q));

   // count and buffer-enable registers
   always_ff @(posedge clk) begin
      if (srst) begin
         cnt  <= '0;
         e32b <= 1'b0;
      end else begin
         if (eng_cnt_ld)
            cnt <= eng_cnt_data;
         else if (reg_wr && (sel == SEL_CNT))
            cnt <= reg_wdata;
         if (reg_wr && (sel == SEL_AUX))
            e32b <= reg_wdata[AUX_BUF_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_CNT: reg_rdata = cnt;
         SEL_DAT: reg_rdata = e32b ? sw_q : '0;
         SEL_AUX: reg_rdata[AUX_BUF_BIT] = e32b;
         default: reg_rdata = '0;
      endcase
   end

   assign eng_pop_data = e32b ? eng_q : '0;
   assign buf_mode     = e32b;
   assign cnt_bad      = (cnt == '0) || (cnt > CNT_MAX);

   // R8: with the buffer off, software data accesses leave the index alone
   a_r8_sw_idle: assert property (@(posedge clk) disable iff (srst)
      (!e32b && (reg_wr || reg_rd) && (sel == SEL_DAT)) |=> $stable(sw_idx));
   // R8: with the buffer off, engine accesses leave the pointer alone
   a_r8_eng_idle: assert property (@(posedge clk) disable iff (srst)
      (!e32b && (eng_pop || eng_push) && !eng_start) |=> $stable(eng_idx));
   // R5: an engine count load wins
   a_r5_eng_cnt: assert property (@(posedge clk) disable iff (srst)
      eng_cnt_ld |=> (cnt == $past(eng_cnt_data)));
   // R8: off-mode pops never hand out stored data
   a_r8_pop_zero: assert property (@(posedge clk) disable iff (srst)
      !e32b |-> (eng_pop_data == '0));
endmodule

// File: tb/tb_smb_blkbuf.sv
`timescale 1ns/1ps
module tb_smb_blkbuf;
   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic [1:0] reg_sel = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       buf_mode, cnt_bad;
   logic       eng_start = 1'b0, eng_pop = 1'b0, eng_push = 1'b0, eng_cnt_ld = 1'b0;
   logic [7:0] eng_pop_data, eng_push_data = '0, eng_cnt_data = '0;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   int         q_kind[$];
   logic [7:0] q_exp[$];
   string      q_tag[$];

   always #4 clk = ~clk;   // 125 MHz

   smb_blkbuf dut (
      .clk(clk), .srst(srst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_mode(buf_mode), .cnt_bad(cnt_bad),
      .eng_start(eng_start), .eng_pop(eng_pop), .eng_pop_data(eng_pop_data),
      .eng_push(eng_push), .eng_push_data(eng_push_data),
      .eng_cnt_ld(eng_cnt_ld), .eng_cnt_data(eng_cnt_data));

   function automatic logic [7:0] f_byte(input int i);
      return 8'(i * 7 + 3);
   endfunction
   function automatic logic [7:0] g_byte(input int i);
      return 8'hC0 ^ 8'(i);
   endfunction

   // monitor: compares everything the driver queued for this cycle
   always begin
      @(negedge clk);
      #2;
      while (q_kind.size() > 0) begin
         int k;
         logic [7:0] e, a;
         string t;
         k = q_kind.pop_front();
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         case (k)
            0: a = reg_rdata;
            1: a = eng_pop_data;
            2: a = {7'd0, cnt_bad};
            default: a = {7'd0, buf_mode};
         endcase
         n_chk++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", t, a, e);
         end
      end
   end

   task automatic op(input logic [1:0] s, input logic w, input logic r, input logic [7:0] wd,
                     input logic st, input logic po, input logic pu, input logic [7:0] pd,
                     input logic cl, input logic [7:0] cd);
      @(negedge clk);
      reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = wd;
      eng_start = st; eng_pop = po; eng_push = pu; eng_push_data = pd;
      eng_cnt_ld = cl; eng_cnt_data = cd;
   endtask

   task automatic expect_v(input int k, input logic [7:0] e, input string t);
      q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
   endtask

   task automatic idle();
      op(2'd0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
   endtask
   task automatic sw_wr(input logic [1:0] s, input logic [7:0] d);
      op(s, 1, 0, d, 0, 0, 0, 8'h00, 0, 8'h00);
   endtask
   task automatic sw_rd(input logic [1:0] s, input logic [7:0] e, input string t);
      op(s, 0, 1, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00);
      expect_v(0, e, t);
   endtask
   task automatic eng_go();
      op(2'd0, 0, 0, 8'h00, 1, 0, 0, 8'h00, 0, 8'h00);
   endtask
   task automatic pop_chk(input logic [7:0] e, input string t);
      op(2'd0, 0, 0, 8'h00, 0, 1, 0, 8'h00, 0, 8'h00);
      expect_v(1, e, t);
   endtask
   task automatic push_b(input logic [7:0] d);
      op(2'd0, 0, 0, 8'h00, 0, 0, 1, d, 0, 8'h00);
   endtask

   initial begin
      repeat (3) idle();
      @(negedge clk); srst = 1'b0;
      // R1 reset state
      sw_rd(2'd1, 8'h00, "R1 count after reset");
      sw_rd(2'd3, 8'h00, "R1 aux after reset");
      expect_v(2, 8'h01, "R1 cnt_bad after reset");
      expect_v(3, 8'h00, "R1 buf_mode after reset");

      // R8 buffer off: write ignored, read zero, pop zero
      sw_wr(2'd2, 8'hAA);
      sw_rd(2'd2, 8'h00, "R8 data read while off");
      pop_chk(8'h00, "R8 pop while off");

      // R7 aux register
      sw_wr(2'd3, 8'hFF);
      sw_rd(2'd3, 8'h02, "R7 aux readback");
      expect_v(3, 8'h01, "R7 buf_mode on");

      // R8 the earlier off-mode write did not land; R3 rewind returns zero
      sw_rd(2'd0, 8'h00, "R3 control read value");
      sw_rd(2'd2, 8'h00, "R8 entry 0 untouched while off");

      // R2 fill all entries, R4 one extra write ignored
      sw_rd(2'd0, 8'h00, "R3 rewind");
      for (int i = 0; i < 32; i++) sw_wr(2'd2, f_byte(i));
      sw_wr(2'd2, 8'hEE);
      sw_rd(2'd0, 8'h00, "R3 rewind");
      for (int i = 0; i < 32; i++) sw_rd(2'd2, f_byte(i), "R2 drain in order");
      sw_rd(2'd2, 8'h00, "R4 read past end");

      // R3 rewind mid-way
      sw_rd(2'd0, 8'h00, "R3 rewind");
      for (int i = 0; i < 3; i++) sw_rd(2'd2, f_byte(i), "R2 partial read");
      sw_rd(2'd0, 8'h00, "R3 rewind");
      sw_rd(2'd2, f_byte(0), "R3 after mid-way rewind");

      // R9 engine pops in order, R11 pop past end
      eng_go();
      for (int i = 0; i < 32; i++) pop_chk(f_byte(i), "R9 pop order");
      pop_chk(8'h00, "R11 pop past end");

      // R10 engine pushes, R11 extra push ignored
      eng_go();
      for (int i = 0; i < 32; i++) push_b(g_byte(i));
      push_b(8'h99);
      sw_rd(2'd0, 8'h00, "R3 rewind");
      for (int i = 0; i < 32; i++) sw_rd(2'd2, g_byte(i), "R10 pushed data (R11 on last)");

      // R5/R6 count register and check
      sw_wr(2'd1, 8'h00);
      idle(); expect_v(2, 8'h01, "R6 count 0");
      sw_wr(2'd1, 8'h01);
      idle(); expect_v(2, 8'h00, "R6 count 1");
      sw_wr(2'd1, 8'd32);
      idle(); expect_v(2, 8'h00, "R6 count 32");
      sw_wr(2'd1, 8'd33);
      sw_rd(2'd1, 8'd33, "R5 count readback");
      expect_v(2, 8'h01, "R6 count 33");
      sw_wr(2'd1, 8'hFF);
      idle(); expect_v(2, 8'h01, "R6 count 255");
      op(2'd1, 1, 0, 8'h05, 0, 0, 0, 8'h00, 1, 8'h14);
      sw_rd(2'd1, 8'h14, "R5 engine load wins");
      expect_v(2, 8'h00, "R6 count 20");

      // R8 buffer off: pushes ignored
      sw_wr(2'd3, 8'hFD);
      sw_rd(2'd3, 8'h00, "R7 bit 1 cleared");
      expect_v(3, 8'h00, "R7 buf_mode off");
      eng_go();
      push_b(8'h77);
      pop_chk(8'h00, "R8 pop while off");
      sw_wr(2'd3, 8'h02);
      sw_rd(2'd0, 8'h00, "R3 rewind");
      sw_rd(2'd2, g_byte(0), "R8 entry 0 untouched by off push");
      pop_chk(g_byte(0), "R8 engine pointer did not move");

      repeat (3) idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule